// File: doc/BRIEF.md
# Frame Checksum Engine for a Dual-Channel Time-Triggered Bus

This block produces the two checksums carried by every frame of a dual-channel, time-triggered automotive bus. When a frame begins, the header fields are presented on parallel inputs together with a one-cycle `start` pulse. In the same cycle, the block computes the 11-bit header checksum. It also folds all five header bytes, including that checksum, into the 24-bit frame checksum. The initial value of the frame checksum depends on which bus channel the frame belongs to.

After `start`, the payload streams in one byte per accepted cycle. A byte is accepted when `in_valid` is high, and `in_last` marks the final byte of the frame. One cycle after the final byte, the block pulses `done`, and both checksum outputs then hold their final values until the next accepted `start`.

In check mode, the stream continues past the payload with the three received checksum bytes. The block compares them with its own result and reports a disagreement on `crc_bad`.

Top module: `frame_crc_gen`

## Requirements
- R1: After reset, `done`, `crc_bad`, `hdr_crc` and `trl_crc` are all zero.
- R2: On an accepted `start`, `hdr_crc` takes the checksum of the 20-bit string {sync bit, startup bit, frame ID[10:0], length[6:0]}, processed MSB first, with polynomial x^11+x^9+x^8+x^7+x^2+1 and initial value 0x01A. It keeps that value until the next accepted `start`.
- R3: The frame checksum starts from 0xFEDCBA when `chan_b` is 0 and from 0xABCDEF when `chan_b` is 1, sampled with `start`.
- R4: The frame checksum uses x^24+x^22+x^20+x^19+x^18+x^16+x^14+x^13+x^11+x^10+x^8+x^7+x^6+x^3+x+1. Each byte is processed MSB first. The 40 header bits are covered in bus order {reserved, preamble flag, null flag, sync, startup, ID[10:0], length[6:0], header checksum[10:0], cycle[5:0]}, followed by 2×length payload bytes.
- R5: `done` is high for exactly one cycle, and that cycle immediately follows the accepted byte that has `in_last` high. In generate mode with length 0, `done` is high in the cycle after `start`.
- R6: In check mode (`chk_mode`=1 at `start`), the bytes after the 2×length payload bytes are the received checksum, high byte first. `crc_bad` is 1 together with `done` exactly when the received checksum differs from the computed one.
- R7: A `start` that arrives while a frame is in progress is ignored. The final `hdr_crc` and `trl_crc` of the current frame are unchanged by it.
- R8: Cycles with `in_valid` low do not change the checksum or the byte count, whatever the values of `in_data` and `in_last`.
- R9: `crc_bad` is 0 whenever `done` is 0, and it is always 0 in generate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a frame; header inputs are sampled in this cycle |
| chan_b | input | 1 | 0 selects channel A initial value, 1 selects channel B |
| chk_mode | input | 1 | 1 = received checksum bytes follow the payload |
| hdr_rsv | input | 1 | Reserved header bit |
| hdr_ppi | input | 1 | Payload preamble flag |
| hdr_null | input | 1 | Null frame flag |
| hdr_sync | input | 1 | Sync frame flag |
| hdr_stup | input | 1 | Startup frame flag |
| hdr_fid | input | 11 | Frame ID |
| hdr_len | input | 7 | Payload length in 16-bit words |
| hdr_cyc | input | 6 | Cycle count |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the frame |
| done | output | 1 | One-cycle completion pulse |
| crc_bad | output | 1 | Received checksum mismatch, valid with `done` |
| hdr_crc | output | 11 | Header checksum |
| trl_crc | output | 24 | Frame checksum, final when `done` is high |

## Verification
The assertions rely on three properties of the inputs:
- `in_last` is raised only on the byte that ends the frame.
- In check mode, exactly three checksum bytes follow the payload.
- In generate mode, a frame with a nonzero length ends on its last payload byte.

The bench builds every frame from its length field and the mode, so the byte count always agrees with these properties. Idle cycles inside a frame carry junk data and a raised `in_last`, to show that unstrobed inputs are ignored. The stray `start` is injected only after a frame is already running.

// File: rtl/frame_crc_gen.sv
module frame_crc_gen #(
  parameter int          FIDW   = 11,
  parameter int          LENW   = 7,
  parameter int          CYCW   = 6,
  parameter int          HW     = 11,
  parameter int          TW     = 24,
  parameter logic [10:0] HPOLY  = 11'h385,
  parameter logic [10:0] HSEED  = 11'h01A,
  parameter logic [23:0] TPOLY  = 24'h5D6DCB,
  parameter logic [23:0] SEED_A = 24'hFEDCBA,
  parameter logic [23:0] SEED_B = 24'hABCDEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            chan_b,
  input  logic            chk_mode,
  input  logic            hdr_rsv,
  input  logic            hdr_ppi,
  input  logic            hdr_null,
  input  logic            hdr_sync,
  input  logic            hdr_stup,
  input  logic [FIDW-1:0] hdr_fid,
  input  logic [LENW-1:0] hdr_len,
  input  logic [CYCW-1:0] hdr_cyc,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  output logic            done,
  output logic            crc_bad,
  output logic [HW-1:0]   hdr_crc,
  output logic [TW-1:0]   trl_crc
);
  localparam int HBITS = 2 + FIDW + LENW;
  localparam int VBITS = 5 + FIDW + LENW + HW + CYCW;
  localparam int CW    = LENW + 3;

  function automatic logic [HW-1:0] hcalc(input logic [HBITS-1:0] v);
    logic [HW-1:0] c = HSEED[HW-1:0];
    for (int i = HBITS - 1; i >= 0; i--) begin
      logic fb = v[i] ^ c[HW-1];
      c = {c[HW-2:0], 1'b0};
      if (fb) c = c ^ HPOLY[HW-1:0];
    end
    return c;
  endfunction

  function automatic logic [TW-1:0] thdr(input logic [TW-1:0] s, input logic [VBITS-1:0] v);
    logic [TW-1:0] c = s;
    for (int i = VBITS - 1; i >= 0; i--) begin
      logic fb = v[i] ^ c[TW-1];
      c = {c[TW-2:0], 1'b0};
      if (fb) c = c ^ TPOLY[TW-1:0];
    end
    return c;
  endfunction

  function automatic logic [TW-1:0] tbyte(input logic [TW-1:0] s, input logic [7:0] b);
    logic [TW-1:0] c = s;
    for (int i = 7; i >= 0; i--) begin
      logic fb = b[i] ^ c[TW-1];
      c = {c[TW-2:0], 1'b0};
      if (fb) c = c ^ TPOLY[TW-1:0];
    end
    return c;
  endfunction

  logic            busy, chk_q;
  logic [LENW-1:0] len_q;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   tcrc, rx;

  wire              start_ok = start && !busy;
  wire              acc      = busy && in_valid;
  wire              in_pay   = cnt < CW'({len_q, 1'b0});
  wire [HW-1:0]     hc_new   = hcalc({hdr_sync, hdr_stup, hdr_fid, hdr_len});
  wire [VBITS-1:0]  hdr_vec  = {hdr_rsv, hdr_ppi, hdr_null, hdr_sync, hdr_stup,
                                hdr_fid, hdr_len, hc_new, hdr_cyc};
  wire [TW-1:0]     seed     = chan_b ? SEED_B[TW-1:0] : SEED_A[TW-1:0];
  wire [TW-1:0]     tc_nx    = (acc && in_pay) ? tbyte(tcrc, in_data) : tcrc;
  wire [TW-1:0]     rx_nx    = (acc && !in_pay) ? {rx[TW-9:0], in_data} : rx;

  assign trl_crc = tcrc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      chk_q   <= 1'b0;
      len_q   <= '0;
      cnt     <= '0;
      tcrc    <= '0;
      rx      <= '0;
      hdr_crc <= '0;
      done    <= 1'b0;
      crc_bad <= 1'b0;
    end else begin
      done    <= 1'b0;
      crc_bad <= 1'b0;
      if (start_ok) begin
        hdr_crc <= hc_new;
        tcrc    <= thdr(seed, hdr_vec);
        len_q   <= hdr_len;
        chk_q   <= chk_mode;
        cnt     <= '0;
        rx      <= '0;
        if (!chk_mode && hdr_len == '0) done <= 1'b1;
        else                             busy <= 1'b1;
      end else if (acc) begin
        tcrc <= tc_nx;
        rx   <= rx_nx;
        cnt  <= cnt + 1'b1;
        if (in_last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          crc_bad <= chk_q && (tc_nx != rx_nx);
        end
      end
    end
  end
endmodule

module frame_crc_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        in_valid,
  input logic        in_last,
  input logic        done,
  input logic        crc_bad,
  input logic [10:0] hdr_crc,
  input logic [23:0] trl_crc
);
  a_r9_bad_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    crc_bad |-> done);
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid && in_last) |=> done);
  a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(hdr_crc));
  a_r2_hdr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(hdr_crc));
  a_r8_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_valid) |=> $stable(trl_crc));
endmodule

bind frame_crc_gen frame_crc_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .in_valid(in_valid),
  .in_last(in_last), .done(done), .crc_bad(crc_bad), .hdr_crc(hdr_crc),
  .trl_crc(trl_crc)
);

// File: tb/tb_frame_crc_gen.sv
module tb_frame_crc_gen;
  logic clk = 0, rst_n = 0;
  logic start = 0, chan_b = 0, chk_mode = 0;
  logic hdr_rsv = 0, hdr_ppi = 0, hdr_null = 0, hdr_sync = 0, hdr_stup = 0;
  logic [10:0] hdr_fid = 0;
  logic [6:0]  hdr_len = 0;
  logic [5:0]  hdr_cyc = 0;
  logic        in_valid = 0, in_last = 0;
  logic [7:0]  in_data = 0;
  logic        done, crc_bad;
  logic [10:0] hdr_crc;
  logic [23:0] trl_crc;
  int nchk = 0, nfail = 0;
  logic [7:0] pay [0:253];

  always #5 clk = ~clk;

  frame_crc_gen dut (.*);

  function automatic logic [10:0] ref_h(input logic [19:0] v);
    logic [10:0] c = 11'h01A;
    for (int i = 19; i >= 0; i--) begin
      logic fb = v[i] ^ c[10];
      c = {c[9:0], 1'b0};
      if (fb) c ^= 11'h385;
    end
    return c;
  endfunction

  function automatic logic [23:0] ref_t(input logic [23:0] s, input logic [7:0] b);
    logic [23:0] c = s;
    for (int i = 7; i >= 0; i--) begin
      logic fb = b[i] ^ c[23];
      c = {c[22:0], 1'b0};
      if (fb) c ^= 24'h5D6DCB;
    end
    return c;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 done", {31'b0, done}, 0);
    chk("R1 crc_bad", {31'b0, crc_bad}, 0);
    chk("R1 hdr_crc", {21'b0, hdr_crc}, 0);
    chk("R1 trl_crc", {8'b0, trl_crc}, 0);
  endtask

  task automatic run_frame(input logic chb, input logic cm, input logic [6:0] len,
                           input logic [10:0] fid, input logic sy, input logic su,
                           input logic [5:0] cyc, input bit gaps, input bit corrupt,
                           input bit busy_start, input string tag);
    logic [10:0] hc;
    logic [39:0] hv;
    logic [23:0] tc;
    int n;
    hc = ref_h({sy, su, fid, len});
    hv = {1'b0, fid[0], 1'b1, sy, su, fid, len, hc, cyc};
    tc = chb ? 24'hABCDEF : 24'hFEDCBA;
    for (int b = 4; b >= 0; b--) tc = ref_t(tc, hv[b*8 +: 8]);
    for (int k = 0; k < 2 * len; k++) tc = ref_t(tc, pay[k]);
    n = 2 * len + (cm ? 3 : 0);
    @(negedge clk);
    start = 1; chan_b = chb; chk_mode = cm; hdr_rsv = 0; hdr_ppi = fid[0];
    hdr_null = 1; hdr_sync = sy; hdr_stup = su; hdr_fid = fid; hdr_len = len; hdr_cyc = cyc;
    @(negedge clk);
    start = 0;
    if (n > 0) chk({"R5 no early done ", tag}, {31'b0, done}, 0);
    for (int k = 0; k < n; k++) begin
      if (gaps) begin
        in_valid = 0; in_data = 8'h5A ^ 8'(k); in_last = 1;
        @(negedge clk);
      end
      in_valid = 1; in_last = (k == n - 1);
      if (k < 2 * len) in_data = pay[k];
      else begin
        in_data = tc[(2 - (k - 2 * len)) * 8 +: 8];
        if (corrupt && k == 2 * len + 1) in_data ^= 8'h10;
      end
      if (busy_start && k == 0) begin
        start = 1; hdr_fid = ~fid; hdr_len = len + 7'd3; chan_b = ~chb;
      end
      @(negedge clk);
      start = 0;
    end
    in_valid = 0; in_last = 0;
    chk({"R5 done ", tag}, {31'b0, done}, 1);
    chk({"R2 hdr_crc ", tag}, {21'b0, hdr_crc}, {21'b0, hc});
    chk({"R4 trl_crc ", tag}, {8'b0, trl_crc}, {8'b0, tc});
    chk({"R6 crc_bad ", tag}, {31'b0, crc_bad}, {31'b0, cm & corrupt});
    @(negedge clk);
    chk({"R5 single done ", tag}, {31'b0, done}, 0);
    chk({"R9 bad low ", tag}, {31'b0, crc_bad}, 0);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 254; i++) pay[i] = 8'((i * 37 + 11) & 8'hFF);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    run_frame(0, 0, 7'd4,   11'h123, 1, 1, 6'd5,  0, 0, 0, "R3 chanA gen");
    run_frame(1, 0, 7'd4,   11'h123, 1, 1, 6'd5,  0, 0, 0, "R3 chanB gen");
    run_frame(0, 0, 7'd0,   11'h7FF, 0, 0, 6'd63, 0, 0, 0, "R5 zero len gen");
    run_frame(1, 1, 7'd0,   11'h001, 1, 0, 6'd0,  0, 0, 0, "R6 zero len chk");
    run_frame(0, 1, 7'd9,   11'h2A5, 1, 1, 6'd17, 0, 0, 0, "R6 chk good");
    run_frame(1, 1, 7'd9,   11'h2A5, 1, 1, 6'd17, 0, 1, 0, "R6 chk bad");
    run_frame(0, 0, 7'd6,   11'h055, 0, 1, 6'd33, 1, 0, 0, "R8 gaps");
    run_frame(1, 1, 7'd3,   11'h400, 1, 0, 6'd2,  0, 0, 1, "R7 busy start");
    run_frame(0, 1, 7'd127, 11'h3C3, 0, 0, 6'd44, 0, 0, 0, "R4 max len");
    run_frame(1, 0, 7'd1,   11'h000, 0, 0, 6'd1,  1, 0, 0, "R9 gen one word");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule